// File: doc/BRIEF.md
# Reset Time-out Sequencer

This block keeps a processor core in reset after a power-on pulse, a brown-out, an external reset or a wake from sleep. It releases the core only when a chain of time-outs has finished. Which links of the chain run depends on configuration inputs:

- A power-up delay, timed on a slow internal tick.
- An oscillator start-up count, timed on oscillator cycles.
- A PLL lock delay, timed on the slow tick.

Every delay is a parameter. The analog detectors, the oscillator and the PLL are outside the block. They reach it only as a pulse, a level and two strobes.

The external reset pin is active low. The time-outs do not wait for this pin. When the last time-out finishes with the pin still low, the sequencer parks in a waiting phase. It releases the core on the first clock edge that samples the pin high.

Brown-out recovery is handled differently from power-on. Brown-out is filtered against short dips. It re-runs only the power-up delay. If the supply fails again while that delay runs, the delay starts over from zero.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the clock edge after any edge that samples `por_i` high, `phase_o` is 0 (power-on idle) and `core_rst_o` is 1. A power-on pulse aborts any phase.
- R2: `phase_o` codes are: 0 power-on idle, 1 power-up timer, 2 oscillator start-up, 3 PLL lock, 4 waiting for pin, 5 run, 6 brown-out hold. `core_rst_o` is 0 only in code 5.
- R3: With `cfg_pwrt_en_i` set, the power-up phase is the first phase after power-on. It ends on the edge that samples the PWRT_TICKS-th `rc_tick_i` strobe. Without RC strobes it does not advance.
- R4: The oscillator start-up phase follows only in crystal modes (`cfg_osc_mode_i` 0, 1 or 2; the value 3 is the RC mode, which skips the phase). It ends on the OST_CYCLES-th `osc_tick_i` strobe.
- R5: With `cfg_pll_en_i` set, a PLL lock phase of PLL_TICKS `rc_tick_i` strobes follows the start-up phase, or follows whichever earlier phase ran.
- R6: In RC mode with the power-up timer and the PLL off, and the pin high, `core_rst_o` falls on the first edge that samples `por_i` low.
- R7: When the chain ends with `ext_rst_n_i` low, the phase is 4. The core is released on the first edge that samples the pin high. The pin sampled low in run returns the phase to 4 on that edge.
- R8: A `wake_i` sample in run in a crystal mode starts the start-up phase, then the PLL phase if enabled, then release. In RC mode a wake has no effect.
- R9: With `cfg_bor_en_i` set, `vdd_ok_i` sampled low on BOR_FILT+1 consecutive edges enters brown-out hold. This applies in phases 2, 3, 4 and 5. Shorter dips, or any dip with the enable clear, have no effect.
- R10: Brown-out hold lasts while `vdd_ok_i` is low. Recovery runs the full power-up delay if enabled, then releases without the start-up or PLL phases.
- R11: In the power-up phase with brown-out enabled, a single low `vdd_ok_i` sample returns to brown-out hold. The delay restarts in full on recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer state |
| por_i | input | 1 | Power-on pulse from the analog detector |
| vdd_ok_i | input | 1 | Supply-above-threshold comparator level |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| wake_i | input | 1 | Wake-from-sleep request |
| cfg_pwrt_en_i | input | 1 | Power-up timer enable |
| cfg_bor_en_i | input | 1 | Brown-out detection enable |
| cfg_pll_en_i | input | 1 | PLL enable |
| cfg_osc_mode_i | input | 2 | Oscillator mode: 0, 1, 2 crystal types, 3 RC |
| osc_tick_i | input | 1 | One strobe per oscillator cycle |
| rc_tick_i | input | 1 | Strobe from the internal RC timebase |
| core_rst_o | output | 1 | Core reset level, high holds the core |
| phase_o | output | 3 | Current phase code |

## Verification
Two collisions are provoked on purpose.

The first is a brown-out dip against the power-up delay's final tick. The supply is dropped so that its single low sample lands on the very edge where the delay would end. The bench then expects the brown-out hold code rather than a release. After recovery it expects the full delay again.

The second is a power-on pulse arriving while the start-up count runs. The bench expects the idle code on the next edge, whatever the counter held.

Randomised configurations and dip lengths are judged against release latencies and trip outcomes. These are computed by bench functions from the phase lengths.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE_POR  = 3'd0,
        PH_PWRT      = 3'd1,
        PH_OST       = 3'd2,
        PH_PLL       = 3'd3,
        PH_WAIT_PIN  = 3'd4,
        PH_RUN       = 3'd5,
        PH_BOR_HOLD  = 3'd6
    } phase_e;

    localparam logic [1:0] OSC_MODE_RC = 2'd3;

    typedef struct packed {
        phase_e phase;
        logic   bor_path;
    } seq_state_t;

endpackage

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done_o = en_i && tick_i && (cnt_q == limit_i - CNT_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || !en_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // the running count never reaches the limit of the active phase
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/rst_seq_bor_filter.sv
module rst_seq_bor_filter #(
    parameter int BOR_FILT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic vdd_ok_i,
    output logic trip_o
);

    localparam int FW = (BOR_FILT > 0) ? $clog2(BOR_FILT + 1) : 1;
    localparam logic [FW-1:0] FILT_MAX = FW'(BOR_FILT);

    logic [FW-1:0] low_d, low_q;

    always_comb begin
        low_d = low_q;
        if (vdd_ok_i)              low_d = '0;
        else if (low_q != FILT_MAX) low_d = low_q + FW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_q <= '0;
        else        low_q <= low_d;
    end

    assign trip_o = en_i && !vdd_ok_i && (low_q == FILT_MAX);

    generate
        if (BOR_FILT > 0) begin : g_filt_chk
            // a trip always follows at least one earlier low sample
            p_trip_filtered_r9: assert property (@(posedge clk) disable iff (!rst_n)
                trip_o |-> $past(!vdd_ok_i));
        end
    endgenerate

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int PWRT_TICKS = 72,
    parameter int OST_CYCLES = 1024,
    parameter int PLL_TICKS  = 2,
    parameter int BOR_FILT   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_i,
    input  logic       vdd_ok_i,
    input  logic       ext_rst_n_i,
    input  logic       wake_i,
    input  logic       cfg_pwrt_en_i,
    input  logic       cfg_bor_en_i,
    input  logic       cfg_pll_en_i,
    input  logic [1:0] cfg_osc_mode_i,
    input  logic       osc_tick_i,
    input  logic       rc_tick_i,
    output logic       core_rst_o,
    output logic [2:0] phase_o
);

    localparam int MAX_AB  = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES;
    localparam int MAX_LIM = (MAX_AB > PLL_TICKS) ? MAX_AB : PLL_TICKS;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    seq_state_t s_d, s_q;

    logic             xtal_mode;
    logic             trip;
    logic             tmr_en;
    logic             tmr_clr;
    logic             tmr_tick;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_limit;
    phase_e           tail_ph;
    phase_e           after_ost_ph;
    phase_e           after_pwrt_por_ph;
    phase_e           start_ph;
    phase_e           after_pwrt_ph;

    assign xtal_mode = (cfg_osc_mode_i != OSC_MODE_RC);

    // chain of follow-on phases, resolved so skipped links cost no cycle
    always_comb begin
        tail_ph           = ext_rst_n_i ? PH_RUN : PH_WAIT_PIN;
        after_ost_ph      = cfg_pll_en_i ? PH_PLL : tail_ph;
        after_pwrt_por_ph = xtal_mode ? PH_OST : after_ost_ph;
        start_ph          = cfg_pwrt_en_i ? PH_PWRT : after_pwrt_por_ph;
        after_pwrt_ph     = s_q.bor_path ? tail_ph : after_pwrt_por_ph;
    end

    // timer source selection
    always_comb begin
        tmr_en    = 1'b0;
        tmr_tick  = rc_tick_i;
        tmr_limit = CNT_W'(PWRT_TICKS);
        unique case (s_q.phase)
            PH_PWRT: tmr_en = 1'b1;
            PH_OST: begin
                tmr_en    = 1'b1;
                tmr_tick  = osc_tick_i;
                tmr_limit = CNT_W'(OST_CYCLES);
            end
            PH_PLL: begin
                tmr_en    = 1'b1;
                tmr_limit = CNT_W'(PLL_TICKS);
            end
            default: ;
        endcase
    end

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE_POR: begin
                s_d.bor_path = 1'b0;
                s_d.phase    = start_ph;
            end
            PH_PWRT: begin
                if (cfg_bor_en_i && !vdd_ok_i) begin
                    s_d.phase    = PH_BOR_HOLD;
                    s_d.bor_path = 1'b1;
                end else if (tmr_done) begin
                    s_d.phase = after_pwrt_ph;
                end
            end
            PH_OST: begin
                if (trip) begin
                    s_d.phase    = PH_BOR_HOLD;
                    s_d.bor_path = 1'b1;
                end else if (tmr_done) begin
                    s_d.phase = after_ost_ph;
                end
            end
            PH_PLL: begin
                if (trip) begin
                    s_d.phase    = PH_BOR_HOLD;
                    s_d.bor_path = 1'b1;
                end else if (tmr_done) begin
                    s_d.phase = tail_ph;
                end
            end
            PH_WAIT_PIN: begin
                if (trip) begin
                    s_d.phase    = PH_BOR_HOLD;
                    s_d.bor_path = 1'b1;
                end else if (ext_rst_n_i) begin
                    s_d.phase = PH_RUN;
                end
            end
            PH_RUN: begin
                if (trip) begin
                    s_d.phase    = PH_BOR_HOLD;
                    s_d.bor_path = 1'b1;
                end else if (!ext_rst_n_i) begin
                    s_d.phase = PH_WAIT_PIN;
                end else if (wake_i && xtal_mode) begin
                    s_d.phase    = PH_OST;
                    s_d.bor_path = 1'b0;
                end
            end
            PH_BOR_HOLD: begin
                s_d.bor_path = 1'b1;
                if (vdd_ok_i) s_d.phase = cfg_pwrt_en_i ? PH_PWRT : tail_ph;
            end
            default: s_d.phase = PH_IDLE_POR;
        endcase
        if (por_i) begin
            s_d.phase    = PH_IDLE_POR;
            s_d.bor_path = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase    <= PH_IDLE_POR;
            s_q.bor_path <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tmr_clr    = (s_d.phase != s_q.phase);
    assign core_rst_o = (s_q.phase != PH_RUN);
    assign phase_o    = s_q.phase;

    rst_seq_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (tmr_en),
        .clr_i   (tmr_clr),
        .tick_i  (tmr_tick),
        .limit_i (tmr_limit),
        .done_o  (tmr_done)
    );

    rst_seq_bor_filter #(
        .BOR_FILT (BOR_FILT)
    ) u_bor_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (cfg_bor_en_i),
        .vdd_ok_i (vdd_ok_i),
        .trip_o   (trip)
    );

    p_por_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> (phase_o == 3'd0) && core_rst_o);

    p_release_needs_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_o) |-> $past(ext_rst_n_i));

    p_pwrt_brownout_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_PWRT && cfg_bor_en_i && !vdd_ok_i && !por_i)
        |=> (s_q.phase == PH_BOR_HOLD));

    p_bor_hold_stay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_BOR_HOLD && !vdd_ok_i && !por_i) |=> (s_q.phase == PH_BOR_HOLD));

    p_wake_rc_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_RUN && wake_i && !xtal_mode && ext_rst_n_i && !trip && !por_i)
        |=> !core_rst_o);

endmodule

// File: tb/rst_seq_ctrl_bench.sv
`timescale 1ns/1ps
module rst_seq_ctrl_bench;

    localparam int P = 20;
    localparam int O = 1024;
    localparam int L = 30;
    localparam int F = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por = 1'b0;
    logic       vdd = 1'b1;
    logic       pin = 1'b1;
    logic       wake = 1'b0;
    logic       pwrt_en = 1'b0;
    logic       bor_en = 1'b0;
    logic       pll_en = 1'b0;
    logic [1:0] mode = 2'd3;
    logic       osc_t = 1'b1;
    logic       rc_t = 1'b1;
    logic       core_rst;
    logic [2:0] phase;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rst_seq_ctrl #(
        .PWRT_TICKS (P),
        .OST_CYCLES (O),
        .PLL_TICKS  (L),
        .BOR_FILT   (F)
    ) u_rst_seq_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .por_i          (por),
        .vdd_ok_i       (vdd),
        .ext_rst_n_i    (pin),
        .wake_i         (wake),
        .cfg_pwrt_en_i  (pwrt_en),
        .cfg_bor_en_i   (bor_en),
        .cfg_pll_en_i   (pll_en),
        .cfg_osc_mode_i (mode),
        .osc_tick_i     (osc_t),
        .rc_tick_i      (rc_t),
        .core_rst_o     (core_rst),
        .phase_o        (phase)
    );

    function automatic int exp_por(bit pw, logic [1:0] m, bit pl);
        return (pw ? P : 0) + ((m != 2'd3) ? O : 0) + (pl ? L : 0);
    endfunction

    function automatic int exp_wake(logic [1:0] m, bit pl);
        return (m != 2'd3) ? (O + (pl ? L : 0)) : 0;
    endfunction

    function automatic bit exp_trip(bit en, int len);
        return en && (len > F);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input int start, output int n);
        n = start;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (!core_rst) break;
            n++;
        end
    endtask

    task automatic por_seq(output int n);
        @(negedge clk);
        por = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 phase during por", int'(phase), 0);
        chk("R1 core_rst during por", int'(core_rst), 1);
        por = 1'b0;
        measure(0, n);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(150000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        int n;
        int unsigned seed_sink;
        seed_sink = $urandom(32'h00C0FFEE);

        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 reset phase", int'(phase), 0);
        chk("R1 reset core_rst", int'(core_rst), 1);
        rst_n = 1'b1;

        // R6 no time-out at all
        mode = 2'd3; pwrt_en = 0; pll_en = 0;
        por_seq(n);
        chk("R6 immediate release", n, 0);
        chk("R2 run code", int'(phase), 5);

        // R3 R4 R5 full chain
        mode = 2'd2; pwrt_en = 1; pll_en = 1;
        por_seq(n);
        chk("R3/R4/R5 full chain latency", n, exp_por(1, 2'd2, 1));

        // R3 RC tick gating
        mode = 2'd3; pwrt_en = 1; pll_en = 0; rc_t = 0;
        @(negedge clk); por = 1;
        @(negedge clk); por = 0;
        repeat (50) @(negedge clk);
        chk("R3 pwrt holds without rc ticks", int'(phase), 1);
        rc_t = 1;
        measure(0, n);
        chk("R3 pwrt length in ticks", n, P - 1);

        // R1 abort during start-up count
        mode = 2'd1; pwrt_en = 1; pll_en = 0;
        @(negedge clk); por = 1;
        @(negedge clk); por = 0;
        repeat (P + 10) @(negedge clk);
        chk("R4 in start-up phase", int'(phase), 2);
        por = 1; wake = 1;
        @(negedge clk);
        chk("R1 por aborts start-up", int'(phase), 0);
        por = 0; wake = 0;
        measure(0, n);
        chk("R4 restarted chain", n, exp_por(1, 2'd1, 0));

        // R7 pin held low
        mode = 2'd3; pwrt_en = 1; pll_en = 0;
        pin = 0;
        @(negedge clk); por = 1;
        @(negedge clk); por = 0;
        repeat (P + 5) @(negedge clk);
        chk("R7 waiting for pin", int'(phase), 4);
        pin = 1;
        @(negedge clk);
        chk("R7 release one edge after pin", int'(core_rst), 0);
        pin = 0;
        @(negedge clk);
        chk("R7 pin low in run", int'(phase), 4);
        pin = 1;
        @(negedge clk);
        chk("R7 rerelease", int'(phase), 5);

        // R8 wake
        mode = 2'd0; pll_en = 1;
        wake = 1;
        @(negedge clk);
        wake = 0;
        chk("R8 wake enters start-up", int'(phase), 2);
        measure(1, n);
        chk("R8 wake latency", n, exp_wake(2'd0, 1));
        mode = 2'd3;
        wake = 1;
        @(negedge clk);
        wake = 0;
        chk("R8 wake ignored in RC", int'(core_rst), 0);
        repeat (3) @(negedge clk);
        chk("R8 still running", int'(phase), 5);

        // R9 dips
        bor_en = 1; pwrt_en = 1; pll_en = 0;
        vdd = 0;
        repeat (F) @(negedge clk);
        vdd = 1;
        repeat (3) @(negedge clk);
        chk("R9 short dip ignored", int'(core_rst), 0);
        bor_en = 0;
        vdd = 0;
        repeat (F + 10) @(negedge clk);
        vdd = 1;
        @(negedge clk);
        chk("R9 disabled long dip ignored", int'(phase), 5);
        bor_en = 1;
        vdd = 0;
        repeat (F + 1) @(negedge clk);
        chk("R9 trip to hold", int'(phase), 6);
        repeat (20) @(negedge clk);
        chk("R10 hold while low", int'(phase), 6);

        // R11 coincident dip on the final pwrt edge
        vdd = 1;
        repeat (P) @(negedge clk);
        vdd = 0;
        @(negedge clk);
        chk("R11 dip beats pwrt end", int'(phase), 6);

        // R11 mid-delay dip and full restart, R10 recovery path
        vdd = 1;
        repeat (5) @(negedge clk);
        vdd = 0;
        @(negedge clk);
        chk("R11 mid-delay dip", int'(phase), 6);
        vdd = 1;
        mode = 2'd2; pll_en = 1;
        measure(0, n);
        chk("R10/R11 full pwrt only", n, P);

        // R10 recovery without pwrt
        pwrt_en = 0;
        vdd = 0;
        repeat (F + 3) @(negedge clk);
        vdd = 1;
        measure(0, n);
        chk("R10 no pwrt recovery", n, 0);

        // random configurations
        for (int it = 0; it < 10; it++) begin
            bit pw, pl, be;
            logic [1:0] m;
            int len;
            pw = 1'($urandom);
            pl = 1'($urandom);
            be = 1'($urandom);
            m = 2'($urandom);
            len = 1 + int'($urandom % (F + 4));
            bor_en = 0;
            pwrt_en = pw; pll_en = pl; mode = m;
            por_seq(n);
            chk("R3/R4/R5 random por latency", n, exp_por(pw, m, pl));
            wake = 1;
            @(negedge clk);
            wake = 0;
            chk("R8 random wake start", int'(core_rst), (m != 2'd3) ? 1 : 0);
            if (core_rst) begin
                measure(1, n);
                chk("R8 random wake latency", n, exp_wake(m, pl));
            end
            bor_en = be;
            vdd = 0;
            repeat (len) @(negedge clk);
            chk("R9 random dip outcome", int'(core_rst), int'(exp_trip(be, len)));
            vdd = 1;
            if (core_rst) begin
                measure(0, n);
                chk("R10 random recovery", n, pw ? P : 0);
            end
            @(negedge clk);
        end

        summary();
    end

endmodule